// File: doc/BRIEF.md
# Sub-Word Write Read-Modify-Write Controller

This block sits on the memory side of a bus slave port. It owns a word store where each entry holds 64 data bits and 8 check bits. The check bits form a single-error-correct, double-error-detect code over the word's data bits and its word address. Because the address is part of the code, a word written under one address and read back under another shows up as an error.

A requester that writes all bytes of a word supplies the check bits itself, and the controller stores data and check bits as given. A requester that writes only some bytes cannot produce valid check bits, so the controller does that work without the requester seeing it. It reads the stored word, checks and corrects it, merges in the enabled bytes, encodes the result over address and merged data, and writes it back. An error found during that internal read is reported on a one-cycle error event that carries the type, the address and the syndrome. If that error is uncorrectable, the write is abandoned and the response carries an error flag.

Plain reads return the stored data and check bits without any checking. The requester checks them.

Top module: `rmw_partial_ctrl`

## Requirements
- R1: A read is answered in the cycle after it is accepted. `rsp_valid` is high, `rsp_rdata`/`rsp_rchk` are the stored data and check bits unmodified even when they hold an error, `rsp_err` is low, and no error event is raised.
- R2: A write with all eight byte enables set stores `req_wdata` and `req_wchk` as given, without reading first. It is answered in the next cycle with `rsp_err` low, and `req_ready` stays high.
- R3: A write with at least one byte enable clear is a partial write. `req_ready` is low in the three cycles after acceptance. The response (`rsp_valid` high) arrives in the fourth cycle, together with `req_ready` high again.
- R4: In a partial write, byte k (bits 8k+7..8k) of the stored result comes from `req_wdata` when `req_be[k]` is 1, and otherwise from the corrected old word.
- R5: The stored check bits of a partial write are the code of the vector V = {address, merged data}, with data in V bits 0..63 and the address above them. V bit j is placed at the j-th integer (counting from 0) that is 3 or more and not a power of two. Check bit c (c = 0..6) is the XOR of the V bits whose position has bit c set. Check bit 7 is the XOR of all V bits and check bits 0..6. The `req_wchk` value supplied with a partial write is ignored.
- R6: A single flipped bit in the stored data or check bits is corrected before the merge, and the error event reports it as correctable.
- R7: If the internal read is uncorrectable, the stored word and check bits are left unchanged, the response has `rsp_err` high, and the error event reports it as uncorrectable.
- R8: A word whose check bits were generated for a different address is reported as uncorrectable by a partial write to it.
- R9: During the third cycle after a partial write is accepted, `err_valid` pulses for one cycle, but only if the syndrome is nonzero. The syndrome is the stored check bits XOR the code recomputed over the stored data and the request address. The pulse carries `err_addr`, `err_syndrome` and `err_uncorr`.
- R10: A read that follows a partial write to the same address returns the merged data and the regenerated check bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DATA_W/8 | Byte enables for writes |
| req_wdata | input | DATA_W | Write data |
| req_wchk | input | CHK_W | Check bits for full-width writes |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Partial write abandoned on uncorrectable error |
| rsp_rdata | output | DATA_W | Raw read data |
| rsp_rchk | output | CHK_W | Raw read check bits |
| err_valid | output | 1 | Error event pulse |
| err_uncorr | output | 1 | Event type: 1 uncorrectable, 0 corrected |
| err_addr | output | ADDR_W | Address of the errored word |
| err_syndrome | output | CHK_W | Syndrome of the errored word |

## Verification
Responses to reads and full writes are due one cycle after the accepting edge. Partial writes hold `req_ready` low for three cycles, raise the error event in the third cycle and respond in the fourth. The bench drives inputs on falling edges and samples each of these results on the falling edge of exactly the cycle it is due. It checks `req_ready` in every intermediate cycle. Expected words, check bits and syndromes come from the bench's own encoder and a brute-force single-flip search. Stored contents are observed only through later reads.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_CHK  = 2'd2,
      ST_WR   = 2'd3
   } rmw_state_e;

   // Position of code vector bit idx: the idx-th integer >= 3 that is not a power of two.
   function automatic int unsigned code_pos(input int unsigned idx);
      int unsigned n;
      int unsigned res;
      n   = 0;
      res = 0;
      for (int unsigned q = 3; q < 512; q++) begin
         if (res == 0 && (q & (q - 1)) != 0) begin
            if (n == idx) res = q;
            n++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/rmw_secded_enc.sv
module rmw_secded_enc #(
   parameter int IN_W  = 70,
   parameter int CHK_W = 8
) (
   input  logic [IN_W-1:0]  vec,
   output logic [CHK_W-1:0] chk
);
   localparam int HW = CHK_W - 1;

   logic [HW-1:0][IN_W-1:0] sel;

   for (genvar i = 0; i < IN_W; i++) begin : g_bit
      localparam int unsigned POS = rmw_pkg::code_pos(i);
      for (genvar c = 0; c < HW; c++) begin : g_chk
         if (((POS >> c) & 1) != 0) begin : g_on
            assign sel[c][i] = vec[i];
         end else begin : g_off
            assign sel[c][i] = 1'b0;
         end
      end
   end

   for (genvar c = 0; c < HW; c++) begin : g_par
      assign chk[c] = ^sel[c];
   end

   // R5 overall parity over vector and Hamming bits
   assign chk[HW] = (^vec) ^ (^chk[HW-1:0]);

endmodule

// File: rtl/rmw_secded_fix.sv
module rmw_secded_fix #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 6,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [CHK_W-1:0]  chk_in,
   output logic [DATA_W-1:0] data_fixed,
   output logic [CHK_W-1:0]  syndrome,
   output logic              is_corr,
   output logic              is_uncorr
);
   localparam int HW    = CHK_W - 1;
   localparam int VEC_W = DATA_W + ADDR_W;

   logic [CHK_W-1:0]  recomp;
   logic [HW-1:0]     s_ham;
   logic              s_par;
   logic [DATA_W-1:0] flip;
   logic              chk_only;

   rmw_secded_enc #(.IN_W(VEC_W), .CHK_W(CHK_W)) u_enc (
      .vec ({addr_in, data_in}),
      .chk (recomp)
   );

   assign syndrome = chk_in ^ recomp;
   assign s_ham    = syndrome[HW-1:0];
   assign s_par    = ^syndrome;

   // R6 a single data-bit error points at its own position
   for (genvar i = 0; i < DATA_W; i++) begin : g_flip
      localparam int unsigned POS = rmw_pkg::code_pos(i);
      assign flip[i] = s_par && (s_ham == HW'(POS));
   end

   assign chk_only   = s_par && ((s_ham == '0) || $onehot(s_ham));
   assign is_corr    = (|flip) || chk_only;
   // R8 an address-bit position or a double error never corrects
   assign is_uncorr  = (syndrome != '0) && !is_corr;
   assign data_fixed = data_in ^ flip;

endmodule

// File: rtl/rmw_byte_merge.sv
module rmw_byte_merge #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0]   old_word,
   input  logic [DATA_W-1:0]   new_word,
   input  logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   merged
);
   localparam int BE_W = DATA_W / 8;

   // R4 per-byte lane select
   for (genvar k = 0; k < BE_W; k++) begin : g_lane
      assign merged[8*k +: 8] = be[k] ? new_word[8*k +: 8] : old_word[8*k +: 8];
   end

endmodule

// File: rtl/rmw_word_store.sv
module rmw_word_store #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CHK_W-1:0]  wchk,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [CHK_W-1:0]  rchk
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int WORD_W = DATA_W + CHK_W;

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= {wchk, wdata};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         rchk  <= '0;
      end else if (re) begin
         {rchk, rdata} <= mem[raddr];
      end
   end

   // R3
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(we && re));

endmodule

// File: rtl/rmw_partial_ctrl.sv
module rmw_partial_ctrl #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int ADDR_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   input  logic [CHK_W-1:0]    req_wchk,
   output logic                rsp_valid,
   output logic                rsp_err,
   output logic [DATA_W-1:0]   rsp_rdata,
   output logic [CHK_W-1:0]    rsp_rchk,
   output logic                err_valid,
   output logic                err_uncorr,
   output logic [ADDR_W-1:0]   err_addr,
   output logic [CHK_W-1:0]    err_syndrome
);
   import rmw_pkg::*;

   localparam int BE_W  = DATA_W / 8;
   localparam int VEC_W = DATA_W + ADDR_W;
   localparam int CAP   = (1 << (CHK_W - 1)) - CHK_W;

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (VEC_W > CAP) begin : g_bad_code
      $error("CHK_W too small for DATA_W + ADDR_W");
   end

   rmw_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BE_W-1:0]   be_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] merged_q;
   logic [CHK_W-1:0]  mchk_q;
   logic              uncorr_q;

   logic              accept, full_w, in_wr, in_rd, in_chk;
   logic              st_we, st_re;
   logic [ADDR_W-1:0] st_waddr, st_raddr;
   logic [DATA_W-1:0] st_wdata, st_rdata;
   logic [CHK_W-1:0]  st_wchk, st_rchk;
   logic [DATA_W-1:0] fixed, merged;
   logic [CHK_W-1:0]  syn, new_chk;
   logic              f_corr, f_uncorr;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign full_w    = &req_be;
   assign in_rd     = (state_q == ST_RD);
   assign in_chk    = (state_q == ST_CHK);
   assign in_wr     = (state_q == ST_WR);

   // store port steering: the sequencer owns the store outside IDLE
   assign st_re    = (accept && !req_write) || in_rd;
   assign st_raddr = in_rd ? addr_q : req_addr;
   assign st_we    = (accept && req_write && full_w) || (in_wr && !uncorr_q);
   assign st_waddr = in_wr ? addr_q   : req_addr;
   assign st_wdata = in_wr ? merged_q : req_wdata;
   assign st_wchk  = in_wr ? mchk_q   : req_wchk;

   rmw_word_store #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ADDR_W(ADDR_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (st_we),
      .waddr (st_waddr),
      .wdata (st_wdata),
      .wchk  (st_wchk),
      .re    (st_re),
      .raddr (st_raddr),
      .rdata (st_rdata),
      .rchk  (st_rchk)
   );

   rmw_secded_fix #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHK_W(CHK_W)) u_fix (
      .data_in    (st_rdata),
      .addr_in    (addr_q),
      .chk_in     (st_rchk),
      .data_fixed (fixed),
      .syndrome   (syn),
      .is_corr    (f_corr),
      .is_uncorr  (f_uncorr)
   );

   rmw_byte_merge #(.DATA_W(DATA_W)) u_merge (
      .old_word (fixed),
      .new_word (wdata_q),
      .be       (be_q),
      .merged   (merged)
   );

   // R5 fresh code over address and merged word
   rmw_secded_enc #(.IN_W(VEC_W), .CHK_W(CHK_W)) u_reenc (
      .vec ({addr_q, merged}),
      .chk (new_chk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept && req_write && !full_w) begin
               state_q <= ST_RD;
               addr_q  <= req_addr;
               be_q    <= req_be;
               wdata_q <= req_wdata;
            end
            ST_RD:   state_q <= ST_CHK;
            ST_CHK:  state_q <= ST_WR;
            ST_WR:   state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         merged_q     <= '0;
         mchk_q       <= '0;
         uncorr_q     <= 1'b0;
         err_valid    <= 1'b0;
         err_uncorr   <= 1'b0;
         err_addr     <= '0;
         err_syndrome <= '0;
      end else begin
         err_valid <= in_chk && (syn != '0);
         if (in_chk) begin
            merged_q     <= merged;
            mchk_q       <= new_chk;
            uncorr_q     <= f_uncorr;
            err_uncorr   <= f_uncorr;
            err_addr     <= addr_q;
            err_syndrome <= syn;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= (accept && (!req_write || full_w)) || in_wr;
         rsp_err   <= in_wr && uncorr_q;
      end
   end

   // R1 raw path straight from the store read register
   assign rsp_rdata = st_rdata;
   assign rsp_rchk  = st_rchk;

   // R1
   read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_write) |=> (rsp_valid && !rsp_err && !err_valid));
   // R2
   full_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && (&req_be)) |=> (rsp_valid && !rsp_err && req_ready));
   // R3
   part_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && !(&req_be)) |=> (!req_ready && !rsp_valid));
   // R7
   uncorr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && err_uncorr) |=> (rsp_valid && rsp_err));
   // R9
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |=> (!err_valid && rsp_valid));
   // R9
   err_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (err_syndrome != '0));
   // R6
   corr_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !err_uncorr) |=> (rsp_valid && !rsp_err));

endmodule

// File: tb/tb_rmw_partial_ctrl.sv
module tb_rmw_partial_ctrl;
   localparam int CLK_P = 10;
   localparam int DW = 64;
   localparam int CW = 8;
   localparam int AW = 6;
   localparam int NW = 1 << AW;
   localparam int VW = DW + AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_be = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [CW-1:0] req_wchk = '0;
   logic          rsp_valid, rsp_err, err_valid, err_uncorr;
   logic [DW-1:0] rsp_rdata;
   logic [CW-1:0] rsp_rchk, err_syndrome;
   logic [AW-1:0] err_addr;

   int nvec = 0;
   int nfail = 0;
   int unsigned ptab [VW];
   logic [DW-1:0] sh_d [NW];
   logic [CW-1:0] sh_c [NW];
   logic last_err, last_unc;

   always #(CLK_P/2) clk = ~clk;

   rmw_partial_ctrl #(.DATA_W(DW), .CHK_W(CW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
      .req_wdata(req_wdata), .req_wchk(req_wchk), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rsp_rchk(rsp_rchk),
      .err_valid(err_valid), .err_uncorr(err_uncorr), .err_addr(err_addr),
      .err_syndrome(err_syndrome)
   );

   task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // R5 code built from the stated placement rule
   function automatic logic [CW-1:0] benc(input logic [DW-1:0] d, input logic [AW-1:0] a);
      logic [VW-1:0] v;
      logic [CW-1:0] c;
      v = {a, d};
      c = '0;
      for (int j = 0; j < VW; j++)
         if (v[j])
            for (int b = 0; b < CW - 1; b++)
               if (ptab[j][b]) c[b] = ~c[b];
      c[CW-1] = (^v) ^ (^c[CW-2:0]);
      return c;
   endfunction

   function automatic void classify(input logic [DW-1:0] d, input logic [CW-1:0] c,
                                    input logic [AW-1:0] a, output logic [CW-1:0] syn,
                                    output logic unc, output logic [DW-1:0] fixed);
      logic found;
      syn = c ^ benc(d, a);
      fixed = d;
      found = (syn == '0);
      for (int k = 0; k < DW; k++)
         if (!found && benc(d ^ (64'd1 << k), a) == c) begin
            found = 1'b1;
            fixed = d ^ (64'd1 << k);
         end
      for (int k = 0; k < CW; k++)
         if (!found && benc(d, a) == (c ^ (8'd1 << k))) found = 1'b1;
      unc = !found;
   endfunction

   task automatic do_read(input logic [AW-1:0] a, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = '0;
      @(negedge clk);
      req_valid = 1'b0;
      check_eq({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      check_eq({tag, " rdata"}, rsp_rdata, sh_d[a]);
      check_eq({tag, " rchk"}, 64'(rsp_rchk), 64'(sh_c[a]));
      check_eq({tag, " rsp_err/err_valid"}, {62'd0, rsp_err, err_valid}, 64'd0);
   endtask

   task automatic do_full(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CW-1:0] c);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = 8'hFF;
      req_wdata = d; req_wchk = c;
      @(negedge clk);
      req_valid = 1'b0;
      // R2
      check_eq("R2 rsp", {61'd0, rsp_valid, rsp_err, req_ready}, 64'b101);
      sh_d[a] = d;
      sh_c[a] = c;
   endtask

   task automatic do_part(input logic [AW-1:0] a, input logic [7:0] be, input logic [DW-1:0] d);
      logic [CW-1:0] syn;
      logic unc;
      logic [DW-1:0] fixed, m;
      classify(sh_d[a], sh_c[a], a, syn, unc, fixed);
      for (int k = 0; k < 8; k++) m[8*k +: 8] = be[k] ? d[8*k +: 8] : fixed[8*k +: 8];
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be;
      req_wdata = d; req_wchk = 8'($urandom());
      @(negedge clk);
      req_valid = 1'b0;
      // R3
      check_eq("R3 busy c1", {62'd0, req_ready, rsp_valid}, 64'd0);
      @(negedge clk);
      check_eq("R3 busy c2", {62'd0, req_ready, rsp_valid}, 64'd0);
      @(negedge clk);
      // R9
      check_eq("R9 err_valid", 64'(err_valid), 64'(syn != '0));
      check_eq("R3 busy c3", 64'(req_ready), 64'd0);
      last_err = err_valid;
      last_unc = err_uncorr;
      if (syn != '0) begin
         check_eq("R9 err_addr", 64'(err_addr), 64'(a));
         check_eq("R9 err_syndrome", 64'(err_syndrome), 64'(syn));
         check_eq("R9 err_uncorr", 64'(err_uncorr), 64'(unc));
      end
      @(negedge clk);
      // R3 R7
      check_eq("R3 rsp", {62'd0, rsp_valid, req_ready}, 64'b11);
      check_eq("R7 rsp_err", 64'(rsp_err), 64'(unc));
      check_eq("R9 pulse ends", 64'(err_valid), 64'd0);
      if (!unc) begin
         sh_d[a] = m;
         sh_c[a] = benc(m, a);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin : main
      int unsigned n;
      logic [DW-1:0] d;
      logic [CW-1:0] c;
      n = 0;
      for (int unsigned q = 3; n < VW; q++)
         if ((q & (q - 1)) != 0) begin
            ptab[n] = q;
            n++;
         end
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // reset state: R3 ready, R9 no event
      check_eq("R3 reset ready", 64'(req_ready), 64'd1);
      check_eq("R9 reset outputs", {62'd0, rsp_valid, err_valid}, 64'd0);
      rst_n = 1'b1;
      for (int a = 0; a < NW; a++) begin
         d = {$urandom(), $urandom()};
         do_full(AW'(a), d, benc(d, AW'(a)));
      end
      do_read(6'd5, "R1");
      // clean partial: R4 R5 R10
      do_part(6'd5, 8'h01, 64'h1122334455667788);
      check_eq("R9 clean no event", 64'(last_err), 64'd0);
      do_read(6'd5, "R10 R4 R5");
      // single data bit flip
      d = {$urandom(), $urandom()};
      do_full(6'd7, d ^ 64'h0000_0100_0000_0000, benc(d, 6'd7));
      do_read(6'd7, "R1 raw error");
      do_part(6'd7, 8'hF0, 64'hDEAD_BEEF_0000_0000);
      check_eq("R6 correctable", {62'd0, last_err, last_unc}, 64'b10);
      do_read(6'd7, "R6 R10 corrected");
      // single check bit flip
      d = {$urandom(), $urandom()};
      do_full(6'd8, d, benc(d, 6'd8) ^ 8'h40);
      do_part(6'd8, 8'h80, 64'hAB00_0000_0000_0000);
      check_eq("R6 chk flip", {62'd0, last_err, last_unc}, 64'b10);
      do_read(6'd8, "R6 chk flip readback");
      // double error
      d = {$urandom(), $urandom()};
      do_full(6'd9, d ^ 64'h3, benc(d, 6'd9));
      do_part(6'd9, 8'h0F, 64'h0);
      check_eq("R7 uncorrectable", {62'd0, last_err, last_unc}, 64'b11);
      do_read(6'd9, "R7 unchanged");
      // address mismatch
      d = {$urandom(), $urandom()};
      do_full(6'd11, d, benc(d, 6'd12));
      do_part(6'd11, 8'h02, 64'hFFFF);
      check_eq("R8 addr mismatch", {62'd0, last_err, last_unc}, 64'b11);
      do_read(6'd11, "R8 unchanged");
      // R5 supplied check bits of a partial write ignored, empty mask rewrites
      do_part(6'd20, 8'h00, 64'h0);
      do_read(6'd20, "R5 ignore wchk");
      for (int i = 0; i < 600; i++) begin
         logic [AW-1:0] a;
         int op;
         a = AW'($urandom());
         op = int'($urandom_range(0, 2));
         if (op == 0) do_read(a, "R1 rand");
         else if (op == 1) begin
            logic [DW-1:0] inj;
            d = {$urandom(), $urandom()};
            c = benc(d, a);
            inj = '0;
            case ($urandom_range(0, 7))
               0: inj = 64'd1 << $urandom_range(0, 63);
               1: inj = (64'd1 << $urandom_range(0, 31)) | (64'd1 << $urandom_range(32, 63));
               2: c = c ^ (8'd1 << $urandom_range(0, 7));
               default: ;
            endcase
            do_full(a, d ^ inj, c);
         end else begin
            logic [7:0] be;
            be = 8'($urandom());
            if (be == 8'hFF) be = 8'h7F;
            do_part(a, be, {$urandom(), $urandom()});
         end
      end
      for (int a = 0; a < NW; a++) do_read(AW'(a), "R10 final");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule